// File: doc/BRIEF.md
# Two-button combination lock with attempt limit

The block is a four-digit combination lock driven by two active-low push buttons and shown on an eight-wide LED bar. In every digit-entry phase exactly one LED is lit; its position is the digit currently offered. One button moves the lit position one place up, wrapping from the top position back to the bottom. The other button commits the lit position as the next digit of the code. The position is not cleared when a digit is committed, so the next digit is reached by stepping on from where the last one was.

Both buttons are sampled on a slow enable pulse taken from a free-running counter, so a human press spans many samples. Each button is turned into a single-cycle event on its rising (pressed) edge by a two-stage edge detector. A correct four-digit entry shows a secret byte and stays there. A mistake is not revealed early: after a wrong digit the lock keeps stepping and accepting digits exactly as before, and the attempt only fails after the fourth digit. A failed attempt brings the LED back to position zero. The third failure blanks nothing and lights all eight LEDs for good; only reset leaves that state.

Top module: `combo_lock`

## Requirements
- R1: After reset the LED output is 0x01 (position 0 lit) and no failures are counted.
- R2: Each press of the step button moves the single lit LED from bit i to bit i+1; from bit 7 (0x80) it wraps to bit 0 (0x01).
- R3: A press held for any number of sample periods gives exactly one step; button events occur only on a slow-enable cycle and last one clock.
- R4: A press of the enter button does not move the lit LED; the position carries over into the next digit.
- R5: Entering the code digits (default positions 3, 1, 5, 7, first digit first) shows the secret byte (default 0xA5) on the LEDs; further presses of either button leave it unchanged.
- R6: After a wrong digit, the step button still moves the lit LED during the remaining digits; after the fourth enter the LED returns to 0x01.
- R7: Three correct digits followed by a wrong fourth digit fail the attempt (LED returns to 0x01, secret not shown).
- R8: Failures accumulate across attempts; after two failures a correct entry still opens the lock.
- R9: The third failed attempt drives all LEDs on (0xFF) and that state ignores every button press until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_step_ni | input | 1 | Step button, active low; moves the lit position |
| btn_enter_ni | input | 1 | Enter button, active low; commits the lit position |
| led_o | output | 8 | LED bar: one-hot position, secret byte, or all on |

## Verification
A corrupted position counter shows at once on the LED bar, since the one-hot display follows it combinationally in every entry state. A wrong transition between the correct and wrong chains stays hidden until the fourth enter, so it is seen only one slow-enable period later, when the bar shows the secret byte instead of 0x01 or the reverse. A miscounted failure tally is the slowest to show: it appears only at the end of the third attempt as a missing or premature all-on bar.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_OK1    = 4'd1,
    ST_OK2    = 4'd2,
    ST_OK3    = 4'd3,
    ST_BAD1   = 4'd4,
    ST_BAD2   = 4'd5,
    ST_BAD3   = 4'd6,
    ST_OPEN   = 4'd7,
    ST_CHECK  = 4'd8,
    ST_LOCKED = 4'd9
  } lock_state_e;

  localparam int unsigned NUM_DIGITS = 4;
endpackage

// File: rtl/lock_tick_gen.sv
module lock_tick_gen #(
  parameter int unsigned TICK_BIT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [TICK_BIT-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // one pulse every 2**TICK_BIT clocks
  assign tick_o = &cnt_q;
endmodule

// File: rtl/lock_edge_det.sv
module lock_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic level_i,
  output logic pulse_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else if (tick_i) begin
      s1_q <= level_i;
      s2_q <= s1_q;
    end
  end

  assign pulse_o = tick_i & s1_q & ~s2_q;
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter int unsigned POS_W     = 3,
  parameter int unsigned MAX_TRIES = 3,
  parameter logic [NUM_DIGITS*POS_W-1:0] CODE = {3'd7, 3'd5, 3'd1, 3'd3},
  parameter logic [(1<<POS_W)-1:0] SECRET = 8'hA5,
  localparam int unsigned LED_W  = 1 << POS_W,
  localparam int unsigned FAIL_W = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              step_i,
  input  logic              enter_i,
  output lock_state_e       state_o,
  output logic [FAIL_W-1:0] fails_o,
  output logic [LED_W-1:0]  led_o
);
  lock_state_e       state_q, state_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [FAIL_W-1:0] fail_q, fail_d;
  logic [NUM_DIGITS-1:0] hit;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_hit
    assign hit[g] = (pos_q == CODE[g*POS_W +: POS_W]);
  end

  logic entry_st;
  assign entry_st = (state_q == ST_IDLE) || (state_q == ST_OK1) ||
                    (state_q == ST_OK2)  || (state_q == ST_OK3) ||
                    (state_q == ST_BAD1) || (state_q == ST_BAD2) ||
                    (state_q == ST_BAD3);

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    fail_d  = fail_q;
    if (tick_i) begin
      if (entry_st && step_i) begin
        pos_d = pos_q + 1'b1;
      end else if (entry_st && enter_i) begin
        unique case (state_q)
          ST_IDLE: state_d = hit[0] ? ST_OK1  : ST_BAD1;
          ST_OK1:  state_d = hit[1] ? ST_OK2  : ST_BAD2;
          ST_OK2:  state_d = hit[2] ? ST_OK3  : ST_BAD3;
          ST_OK3:  state_d = hit[3] ? ST_OPEN : ST_CHECK;
          ST_BAD1: state_d = ST_BAD2;
          ST_BAD2: state_d = ST_BAD3;
          ST_BAD3: state_d = ST_CHECK;
          default: state_d = state_q;
        endcase
      end else if (state_q == ST_CHECK) begin
        pos_d = '0;
        if (fail_q == FAIL_W'(MAX_TRIES - 1)) begin
          state_d = ST_LOCKED;
        end else begin
          fail_d  = fail_q + 1'b1;
          state_d = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      fail_q  <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      fail_q  <= fail_d;
    end
  end

  always_comb begin
    if (entry_st)                   led_o = LED_W'(1) << pos_q;
    else if (state_q == ST_OPEN)    led_o = SECRET;
    else if (state_q == ST_LOCKED)  led_o = '1;
    else                            led_o = '0;
  end

  assign state_o = state_q;
  assign fails_o = fail_q;
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int unsigned TICK_BIT  = 20,
  parameter int unsigned POS_W     = 3,
  parameter int unsigned MAX_TRIES = 3,
  parameter logic [NUM_DIGITS*POS_W-1:0] CODE = {3'd7, 3'd5, 3'd1, 3'd3},
  parameter logic [(1<<POS_W)-1:0] SECRET = 8'hA5,
  localparam int unsigned LED_W  = 1 << POS_W,
  localparam int unsigned FAIL_W = $clog2(MAX_TRIES + 1),
  localparam int unsigned NUM_BTN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             btn_step_ni,
  input  logic             btn_enter_ni,
  output logic [LED_W-1:0] led_o
);
  logic                tick;
  logic [NUM_BTN-1:0]  btn_lvl;
  logic [NUM_BTN-1:0]  btn_pls;
  lock_state_e         state;
  logic [FAIL_W-1:0]   fails;

  assign btn_lvl = ~{btn_enter_ni, btn_step_ni};

  lock_tick_gen #(.TICK_BIT(TICK_BIT)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    lock_edge_det u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .level_i (btn_lvl[b]),
      .pulse_o (btn_pls[b])
    );
  end

  lock_fsm #(
    .POS_W     (POS_W),
    .MAX_TRIES (MAX_TRIES),
    .CODE      (CODE),
    .SECRET    (SECRET)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .step_i  (btn_pls[0]),
    .enter_i (btn_pls[1]),
    .state_o (state),
    .fails_o (fails),
    .led_o   (led_o)
  );
endmodule

// File: rtl/lock_chk.sv
module lock_chk
  import lock_pkg::*;
#(
  parameter int unsigned LED_W     = 8,
  parameter int unsigned FAIL_W    = 2,
  parameter int unsigned MAX_TRIES = 3,
  parameter logic [LED_W-1:0] SECRET = 8'hA5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              step_i,
  input logic              enter_i,
  input lock_state_e       state_i,
  input logic [FAIL_W-1:0] fails_i,
  input logic [LED_W-1:0]  led_i
);
  logic entry;
  assign entry = (state_i == ST_IDLE) || (state_i == ST_OK1) ||
                 (state_i == ST_OK2)  || (state_i == ST_OK3) ||
                 (state_i == ST_BAD1) || (state_i == ST_BAD2) ||
                 (state_i == ST_BAD3);

  AST_LED_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |-> ($countones(led_i) == 1)); // R2
  AST_PULSE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i || enter_i) |-> tick_i); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !step_i); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_i)); // R3
  AST_CHECK_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CHECK && tick_i) |=> (state_i != ST_CHECK)); // R6
  AST_OPEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OPEN) |=> (state_i == ST_OPEN && led_i == SECRET)); // R5
  AST_FAIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fails_i < FAIL_W'(MAX_TRIES)); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_LOCKED) |=> (state_i == ST_LOCKED && led_i == '1)); // R9
endmodule

bind combo_lock lock_chk #(
  .LED_W     (LED_W),
  .FAIL_W    (FAIL_W),
  .MAX_TRIES (MAX_TRIES),
  .SECRET    (SECRET)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick),
  .step_i  (btn_pls[0]),
  .enter_i (btn_pls[1]),
  .state_i (state),
  .fails_i (fails),
  .led_i   (led_o)
);

// File: tb/tb_combo_lock.sv
`timescale 1ns/1ps
module tb_combo_lock;
  localparam int TICK_BIT = 2;
  localparam int PER      = 1 << TICK_BIT;
  localparam logic [7:0] SECRET = 8'hA5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic btn_step_ni = 1'b1;
  logic btn_enter_ni = 1'b1;
  logic [7:0] led;

  int checks = 0;
  int errors = 0;
  int cur_pos = 0;

  always #2.5 clk = ~clk;

  combo_lock #(.TICK_BIT(TICK_BIT)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .btn_step_ni  (btn_step_ni),
    .btn_enter_ni (btn_enter_ni),
    .led_o        (led)
  );

  task automatic check(input logic [7:0] exp, input string req);
    checks++;
    if (led !== exp) begin
      errors++;
      $display("FAIL %s: led actual %02h expected %02h", req, led, exp);
    end
  endtask

  task automatic do_reset();
    btn_step_ni = 1'b1;
    btn_enter_ni = 1'b1;
    @(negedge clk) rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    cur_pos = 0;
  endtask

  task automatic press(input bit enter, input int hold_ticks);
    @(negedge clk);
    if (enter) btn_enter_ni = 1'b0; else btn_step_ni = 1'b0;
    repeat (hold_ticks * PER) @(negedge clk);
    btn_step_ni = 1'b1;
    btn_enter_ni = 1'b1;
    repeat (3 * PER) @(negedge clk);
  endtask

  task automatic step();
    press(1'b0, 3);
    cur_pos = (cur_pos + 1) % 8;
  endtask

  task automatic enter_digit(input int d);
    while (cur_pos != d) step();
    press(1'b1, 3);
  endtask

  task automatic fail_attempt();
    enter_digit(0); enter_digit(0); enter_digit(0); enter_digit(0);
    cur_pos = 0;
  endtask

  task automatic t_walk();
    do_reset();
    check(8'h01, "R1 reset");
    step();
    check(8'h02, "R2 step");
    press(1'b0, 10);
    cur_pos = 2;
    check(8'h04, "R3 long hold one step");
    for (int i = 0; i < 5; i++) step();
    check(8'h80, "R2 top");
    step();
    check(8'h01, "R2 wrap");
  endtask

  task automatic t_unlock();
    do_reset();
    enter_digit(3);
    check(8'h08, "R4 enter keeps position");
    enter_digit(1);
    check(8'h02, "R4 carried through wrap");
    enter_digit(5);
    enter_digit(7);
    check(SECRET, "R5 open");
    press(1'b0, 3);
    check(SECRET, "R5 step ignored");
    press(1'b1, 3);
    check(SECRET, "R5 enter ignored");
  endtask

  task automatic t_wrong_first();
    do_reset();
    enter_digit(2);
    step();
    check(8'h08, "R6 step after wrong digit");
    enter_digit(1);
    enter_digit(5);
    check(8'h20, "R6 position still shown");
    enter_digit(7);
    cur_pos = 0;
    check(8'h01, "R6 attempt fails");
  endtask

  task automatic t_wrong_last();
    do_reset();
    enter_digit(3); enter_digit(1); enter_digit(5); enter_digit(6);
    cur_pos = 0;
    check(8'h01, "R7 wrong last digit");
  endtask

  task automatic t_retry();
    do_reset();
    fail_attempt();
    fail_attempt();
    check(8'h01, "R8 two failures");
    enter_digit(3); enter_digit(1); enter_digit(5); enter_digit(7);
    check(SECRET, "R8 open on third try");
  endtask

  task automatic t_lockout();
    do_reset();
    fail_attempt();
    fail_attempt();
    fail_attempt();
    check(8'hFF, "R9 lockout");
    press(1'b0, 3);
    check(8'hFF, "R9 step ignored");
    press(1'b1, 3);
    check(8'hFF, "R9 enter ignored");
    enter_digit(3); enter_digit(1); enter_digit(5); enter_digit(7);
    check(8'hFF, "R9 code ignored");
  endtask

  initial begin
    t_walk();
    t_unlock();
    t_wrong_first();
    t_wrong_last();
    t_retry();
    t_lockout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule